// File: doc/BRIEF.md
# Reset-Warning Drain Sequencer

This block sits between a power controller and a unit that must be brought to a safe point before it is reset. When a reset warning arrives, the block quiesces the unit according to a 2-bit policy and then emits a one-cycle ok-to-reset pulse. That pulse is a posted message, and nothing is expected back.

Four policies are available:

- **Full:** close the host-side request port, then close the internal master port, wait for earlier reads to return their data and for earlier writes to have their data pulled, then wait until every camera PHY lane reports stop state.
- **Drain only:** the full sequence without the lane wait.
- **Lanes only:** the lane wait alone.
- **Immediate:** reply at once.

Unless the freeze-disable input is set, the host interface idle state machine is frozen as the last step before the reply.

Reads and writes in flight are tracked by two up/down counters that move on issue and completion events. A warning is accepted only from the idle state. The request holds, the freeze and the sequence state are cleared only by the actual reset.

Top module: `rstw_drain_sequencer`

## Requirements
- R1: With `drain_mode_i` = 2'b00 and nothing outstanding, `host_hold_o` rises the cycle after the warning is sampled. `mst_hold_o` follows one cycle later. The ok pulse appears 5 clock edges after the warning edge.
- R2: With mode 2'b01 the lane wait is skipped: lane inputs have no effect, and with nothing outstanding the ok pulse comes 4 edges after the warning edge.
- R3: With mode 2'b10 neither hold output rises and the outstanding counts have no effect. Ok comes 2 edges after the warning edge, or 1 edge after the edge on which all lanes are first seen stopped, whichever is later.
- R4: With mode 2'b11, ok is raised on the warning edge itself. There are no holds and no freeze, regardless of counts or lanes.
- R5: In modes 2'b00 and 2'b01 the reply waits for the drain. The read wait ends one edge after the read count reaches zero, and the write wait is evaluated after it.
- R6: In modes 2'b00 and 2'b10 the reply waits until every bit of `lane_stop_i` is 1 (1 means that lane is in stop state).
- R7: When `freeze_off_i` is 0 and the mode is not 2'b11, `idle_freeze_o` rises one cycle before ok and stays high. When `freeze_off_i` is 1 it never rises.
- R8: `ok_to_reset_o` is high for exactly one cycle and at most once between resets.
- R9: Reset clears all outputs. Once raised, a hold or freeze output stays high until reset.
- R10: A warning that arrives while a sequence is running or finished is ignored. Mode and freeze-disable are captured only when a warning is accepted.
- R11: An issue and a completion of the same kind in the same cycle leave that outstanding count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warn_i | input | 1 | Reset warning pulse from the power controller |
| drain_mode_i | input | 2 | Drain policy: 00 full, 01 drain only, 10 lanes only, 11 immediate |
| freeze_off_i | input | 1 | 1 = do not freeze the host idle state machine |
| rd_req_i | input | 1 | A read request is issued |
| rd_rsp_i | input | 1 | Read data for an earlier request has returned |
| wr_req_i | input | 1 | A write request is issued |
| wr_pull_i | input | 1 | Write data for an earlier request has been fetched |
| lane_stop_i | input | LANES | Per-lane stop-state indication |
| host_hold_o | output | 1 | Stop accepting host-side requests |
| mst_hold_o | output | 1 | Stop accepting new internal master requests |
| idle_freeze_o | output | 1 | Freeze the host interface idle state machine |
| ok_to_reset_o | output | 1 | One-cycle ok-to-reset message |

## Verification
The assertions assume the surroundings never report a completion when the matching count is zero, and never issue a request when that count is at its maximum. They also assume no new requests are issued once the master hold is high.

The stimulus loads a few reads and writes before each warning, including one cycle with a simultaneous issue and completion. It then retires exactly that many at chosen edges and never issues anything after the warning. Expected reply edges are computed as a maximum over the per-stage completion edges for each policy.

// File: rtl/rstw_pkg.sv
package rstw_pkg;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'b00,
        MODE_DRAIN = 2'b01,
        MODE_LANES = 2'b10,
        MODE_NOW   = 2'b11
    } drain_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_RD_WAIT,
        ST_WR_WAIT,
        ST_LANE_WAIT,
        ST_FREEZE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        seq_state_e  st;
        drain_mode_e mode;
        logic        frz_off;
        logic        host_hold;
        logic        mst_hold;
        logic        frz;
        logic        ok;
    } seq_regs_t;

endpackage

// File: rtl/rstw_txn_counter.sv
module rstw_txn_counter #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic retire_i,
    output logic empty_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (issue_i && !retire_i) begin
            cnt_d = cnt_q + 1'b1;
        end else if (retire_i && !issue_i) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign empty_o = (cnt_q == '0);

    AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_i && !issue_i) |-> !empty_o) else $error("retire with empty count"); // R11
    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !retire_i) |-> (cnt_q != CNT_MAX)) else $error("issue at full count"); // R11

endmodule

// File: rtl/rstw_seq_fsm.sv
module rstw_seq_fsm
    import rstw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        warn_i,
    input  logic [1:0]  mode_i,
    input  logic        frz_off_i,
    input  logic        rd_empty_i,
    input  logic        wr_empty_i,
    input  logic        lanes_stopped_i,
    output logic        host_hold_o,
    output logic        mst_hold_o,
    output logic        frz_o,
    output logic        ok_o
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.ok = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (warn_i) begin
                    r_d.mode    = drain_mode_e'(mode_i);
                    r_d.frz_off = frz_off_i;
                    unique case (drain_mode_e'(mode_i))
                        MODE_FULL, MODE_DRAIN: begin
                            r_d.st        = ST_HOLD;
                            r_d.host_hold = 1'b1;
                        end
                        MODE_LANES: r_d.st = ST_LANE_WAIT;
                        default: begin
                            r_d.st = ST_DONE;
                            r_d.ok = 1'b1;
                        end
                    endcase
                end
            end
            ST_HOLD: begin
                r_d.st       = ST_RD_WAIT;
                r_d.mst_hold = 1'b1;
            end
            ST_RD_WAIT: begin
                if (rd_empty_i) r_d.st = ST_WR_WAIT;
            end
            ST_WR_WAIT: begin
                if (wr_empty_i) begin
                    if (r_q.mode == MODE_FULL) begin
                        r_d.st = ST_LANE_WAIT;
                    end else begin
                        r_d.st  = ST_FREEZE;
                        r_d.frz = !r_q.frz_off;
                    end
                end
            end
            ST_LANE_WAIT: begin
                if (lanes_stopped_i) begin
                    r_d.st  = ST_FREEZE;
                    r_d.frz = !r_q.frz_off;
                end
            end
            ST_FREEZE: begin
                r_d.st = ST_DONE;
                r_d.ok = 1'b1;
            end
            default: r_d.st = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: MODE_FULL, frz_off: 1'b0,
                     host_hold: 1'b0, mst_hold: 1'b0, frz: 1'b0, ok: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign host_hold_o = r_q.host_hold;
    assign mst_hold_o  = r_q.mst_hold;
    assign frz_o       = r_q.frz;
    assign ok_o        = r_q.ok;

    AST_MST_AFTER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.mst_hold) |-> r_q.host_hold) else $error("master hold before host hold"); // R1
    AST_DRAINED_AT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FREEZE && !r_q.mode[1]) |-> (rd_empty_i && wr_empty_i)) else $error("reply path entered with traffic in flight"); // R5
    AST_LANES_BEFORE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ok && !r_q.mode[0]) |-> $past(lanes_stopped_i, 2)) else $error("ok without lanes stopped"); // R6
    AST_FREEZE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.frz |-> (!r_q.frz_off && r_q.mode != MODE_NOW)) else $error("freeze while disabled"); // R7
    AST_FREEZE_BEFORE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ok && !r_q.frz_off && r_q.mode != MODE_NOW) |-> $past(r_q.frz)) else $error("ok before freeze"); // R7
    AST_OK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ok |=> !r_q.ok) else $error("ok wider than one cycle"); // R8
    AST_HOLDS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.host_hold || r_q.mst_hold || r_q.frz) |=>
        ((r_q.host_hold || !$past(r_q.host_hold)) && (r_q.mst_hold || !$past(r_q.mst_hold))
         && (r_q.frz || !$past(r_q.frz)))) else $error("hold dropped before reset"); // R9

endmodule

// File: rtl/rstw_drain_sequencer.sv
module rstw_drain_sequencer #(
    parameter int LANES = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warn_i,
    input  logic [1:0]       drain_mode_i,
    input  logic             freeze_off_i,
    input  logic             rd_req_i,
    input  logic             rd_rsp_i,
    input  logic             wr_req_i,
    input  logic             wr_pull_i,
    input  logic [LANES-1:0] lane_stop_i,
    output logic             host_hold_o,
    output logic             mst_hold_o,
    output logic             idle_freeze_o,
    output logic             ok_to_reset_o
);
    localparam int KINDS = 2;

    logic [KINDS-1:0] issue_v, retire_v, empty_v;
    logic             lanes_stopped;

    assign issue_v  = {wr_req_i, rd_req_i};
    assign retire_v = {wr_pull_i, rd_rsp_i};

    for (genvar gi = 0; gi < KINDS; gi++) begin : g_trk
        rstw_txn_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_i  (issue_v[gi]),
            .retire_i (retire_v[gi]),
            .empty_o  (empty_v[gi])
        );
    end

    assign lanes_stopped = &lane_stop_i;

    rstw_seq_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .warn_i          (warn_i),
        .mode_i          (drain_mode_i),
        .frz_off_i       (freeze_off_i),
        .rd_empty_i      (empty_v[0]),
        .wr_empty_i      (empty_v[1]),
        .lanes_stopped_i (lanes_stopped),
        .host_hold_o     (host_hold_o),
        .mst_hold_o      (mst_hold_o),
        .frz_o           (idle_freeze_o),
        .ok_o            (ok_to_reset_o)
    );

    AST_NO_ISSUE_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mst_hold_o |-> !(rd_req_i || wr_req_i)) else $error("request issued under hold"); // R5

endmodule

// File: tb/tb_rstw_drain_sequencer.sv
module tb_rstw_drain_sequencer;
    localparam int LANES = 4;
    localparam int W     = 24;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             warn_i;
    logic [1:0]       drain_mode_i;
    logic             freeze_off_i;
    logic             rd_req_i, rd_rsp_i, wr_req_i, wr_pull_i;
    logic [LANES-1:0] lane_stop_i;
    logic             host_hold_o, mst_hold_o, idle_freeze_o, ok_to_reset_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    rstw_drain_sequencer #(.LANES(LANES), .CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .warn_i(warn_i), .drain_mode_i(drain_mode_i),
        .freeze_off_i(freeze_off_i), .rd_req_i(rd_req_i), .rd_rsp_i(rd_rsp_i),
        .wr_req_i(wr_req_i), .wr_pull_i(wr_pull_i), .lane_stop_i(lane_stop_i),
        .host_hold_o(host_hold_o), .mst_hold_o(mst_hold_o),
        .idle_freeze_o(idle_freeze_o), .ok_to_reset_o(ok_to_reset_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; warn_i = 1'b0; drain_mode_i = 2'b00; freeze_off_i = 1'b0;
        rd_req_i = 1'b0; rd_rsp_i = 1'b0; wr_req_i = 1'b0; wr_pull_i = 1'b0;
        lane_stop_i = '1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: outputs cleared by reset
        chk({host_hold_o, mst_hold_o, idle_freeze_o, ok_to_reset_o} == 4'b0, "R9 reset",
            {host_hold_o, mst_hold_o, idle_freeze_o, ok_to_reset_o}, 0);
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // rdn reads outstanding, last retired at edge rdj; one write pulled at edge wrj
    // (-1 = none); lanes stop at edge lnj (-1 = already stopped). Edges counted from the warning edge.
    task automatic run_case(input logic [1:0] m, input logic fd, input int rdn, input int rdj,
                            input int wrj, input int lnj, input bit rewarn, input string tag);
        int  lat;
        bit  ok_a[W], host_a[W], mst_a[W], frz_a[W];
        int  first_ok, ok_cnt, bad_host, bad_mst, bad_frz;
        bit  eh, em, ef;
        do_reset();
        lane_stop_i = (lnj < 0) ? '1 : '0;
        for (int i = 0; i < rdn; i++) begin
            rd_req_i = 1'b1; @(negedge clk); rd_req_i = 1'b0; @(negedge clk);
        end
        if (rdn > 0) begin
            // R11: simultaneous issue and completion keeps the read count
            rd_req_i = 1'b1; rd_rsp_i = 1'b1; @(negedge clk);
            rd_req_i = 1'b0; rd_rsp_i = 1'b0;
        end
        if (wrj >= 0) begin
            wr_req_i = 1'b1; wr_pull_i = 1'b1; @(negedge clk);
            wr_pull_i = 1'b0; @(negedge clk); wr_req_i = 1'b0;
        end
        case (m)
            2'b00: begin
                lat = 5;
                if (rdn > 0) lat = imax(lat, rdj + 4);
                if (wrj >= 0) lat = imax(lat, wrj + 3);
                if (lnj >= 0) lat = imax(lat, lnj + 1);
            end
            2'b01: begin
                lat = 4;
                if (rdn > 0) lat = imax(lat, rdj + 3);
                if (wrj >= 0) lat = imax(lat, wrj + 2);
            end
            2'b10: begin
                lat = 2;
                if (lnj >= 0) lat = imax(lat, lnj + 1);
            end
            default: lat = 0;
        endcase
        warn_i = 1'b1; drain_mode_i = m; freeze_off_i = fd;
        @(posedge clk);
        fork
            begin
                for (int k = 0; k < W; k++) begin
                    @(negedge clk);
                    if (k == 0) warn_i = 1'b0;
                    if (rewarn && k == 1) begin
                        warn_i = 1'b1; drain_mode_i = 2'b11; freeze_off_i = ~fd;
                    end
                    if (rewarn && k == 2) warn_i = 1'b0;
                    ok_a[k] = ok_to_reset_o; host_a[k] = host_hold_o;
                    mst_a[k] = mst_hold_o; frz_a[k] = idle_freeze_o;
                end
            end
            begin
                for (int k = 0; k < W; k++) begin
                    @(negedge clk);
                    rd_rsp_i  = (rdn > 0) && (k >= rdj - rdn) && (k <= rdj - 1);
                    wr_pull_i = (wrj >= 0) && (k == wrj - 1);
                    if (lnj >= 0 && k == lnj - 1) lane_stop_i = '1;
                end
            end
        join
        first_ok = -1; ok_cnt = 0; bad_host = 0; bad_mst = 0; bad_frz = 0;
        for (int k = 0; k < W; k++) begin
            if (ok_a[k]) begin
                ok_cnt++;
                if (first_ok < 0) first_ok = k;
            end
            eh = (m[1] == 1'b0);
            em = (m[1] == 1'b0) && (k >= 1);
            ef = (!fd) && (m != 2'b11) && (k >= lat - 1);
            if (host_a[k] != eh) bad_host++;
            if (mst_a[k] != em) bad_mst++;
            if (frz_a[k] != ef) bad_frz++;
        end
        chk(first_ok == lat, {tag, " reply edge"}, first_ok, lat);
        chk(ok_cnt == 1, "R8 single ok pulse", ok_cnt, 1);
        chk(bad_host == 0 && bad_mst == 0, "R1/R9 hold outputs", bad_host + bad_mst, 0);
        chk(bad_frz == 0, "R7 freeze output", bad_frz, 0);
        // R10: a warning after completion gives no second reply
        warn_i = 1'b1; @(negedge clk); warn_i = 1'b0;
        ok_cnt = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (ok_to_reset_o) ok_cnt++;
        end
        chk(ok_cnt == 0, "R10 late warning ignored", ok_cnt, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int mm = 0; mm < 4; mm++) begin
            for (int ff = 0; ff < 2; ff++) begin
                run_case(mm[1:0], ff[0], 0, 0, -1, -1, 1'b0, "R1 R2 R3 R4 quiet");
            end
        end
        run_case(2'b00, 1'b0, 2, 6, -1, -1, 1'b0, "R5 R11 reads");
        run_case(2'b00, 1'b0, 0, 0, 8, -1, 1'b0, "R5 writes");
        run_case(2'b00, 1'b0, 0, 0, -1, 12, 1'b0, "R6 lanes");
        run_case(2'b00, 1'b1, 3, 5, 4, 7, 1'b0, "R5 R6 R11 combined");
        run_case(2'b01, 1'b0, 1, 7, -1, 100, 1'b0, "R2 R5 lanes ignored");
        run_case(2'b01, 1'b1, 0, 0, 9, 100, 1'b0, "R2 R5 writes");
        run_case(2'b10, 1'b0, 2, 100, 100, 6, 1'b0, "R3 R6 counts ignored");
        run_case(2'b11, 1'b0, 1, 100, -1, 100, 1'b0, "R4 immediate");
        run_case(2'b00, 1'b0, 0, 0, -1, -1, 1'b1, "R10 rewarn full");
        run_case(2'b10, 1'b1, 0, 0, -1, 5, 1'b1, "R10 rewarn lanes");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule